// File: doc/BRIEF.md
# Palette Entry Format Converter

This block takes raw palette words fetched from memory and turns each one into a 25-bit palette entry: one transparency flag and three 8-bit colour channels. It writes the entries into an external palette RAM through a simple write port. The number of entries comes from the pixel-depth code given at the start of a load. The decoding follows a 2-bit palette-format selector and a greyscale (monochrome) select.

A load begins with a one-cycle `loadStart`. The depth code, format and monochrome select are sampled in that same cycle. The block then takes one 32-bit word per cycle while `wordValid` is high. Every word it accepts is also kept in an internal raw store. If the format selector later moves away from the value used for the last conversion, the block converts the stored words again with the new format and rewrites the whole palette, with no new load. Direct-colour depth codes load nothing.

Top module: `palconv_top`

## Requirements
- R1: After reset, `wrEn` and `convDone` are low, and no write happens until a load is started.
- R2: Depth code 1 gives exactly 4 entries, code 2 gives 16 and code 3 gives 256. Each accepted word produces one write in the next cycle. Addresses count up from 0, and `convDone` is high together with the write of the last entry.
- R3: Any other depth code (0 or 4..15) produces no write and no `convDone`, and a later change of the format selector produces none either.
- R4: Format 0 decodes the word as 5-6-5 colour. R = bits 15:11, G = bits 10:5, B = bits 4:0, each placed in the top bits of its byte with zeros below. The transparency flag is 0. The write data is {flag[24], R[23:16], G[15:8], B[7:0]}.
- R5: Format 1 uses the same colour decode as format 0, and takes the transparency flag from word bit 24.
- R6: Format 2 takes R from bits 23:19, G from bits 15:10 and B from bits 7:3, each placed in the top bits of its byte with zeros below. The flag comes from bit 24.
- R7: Format 3 takes R = bits 23:16, G = bits 15:8 and B = bits 7:0 unchanged. The flag comes from bit 24.
- R8: With the monochrome select set, R, G and B all equal word bits 7:0 in every format. The flag still follows the format's rule.
- R9: Words presented after the entry count has been reached, or while no load is running, cause no write.
- R10: After a completed load, a change of the format selector while the block is idle starts a reconversion. All stored entries are rewritten from address 0 up, one per cycle, decoded with the new format and the current monochrome select, and `convDone` marks the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | One-cycle pulse that begins a palette load |
| depthCode | input | 4 | Pixel-depth code, sampled with loadStart |
| palFormat | input | 2 | Palette format selector |
| monoSel | input | 1 | Greyscale select: all channels take the low byte |
| wordValid | input | 1 | wordData carries a palette word this cycle |
| wordData | input | 32 | Raw palette word |
| wrEn | output | 1 | Palette RAM write enable |
| wrAddr | output | 8 | Palette RAM write address |
| wrData | output | 25 | {transparency, R, G, B} |
| convDone | output | 1 | High with the last write of a load or reconversion |

## Verification
On every cycle the assertions check several rules. Every emit becomes a write at the captured index one cycle later, and the index steps by one between entries. The idle state emits nothing, a reconversion streams one entry per cycle, and `convDone` never appears without a write. For format 0 the flag is always clear, colours widened in the format 0/1 decode have zero low bits, and monochrome output has three equal channels. Only the bench scenarios can show the exact decoded value for each format, the total entry count for each depth code, and that extra words are dropped. They also show that a format change rewrites the palette from the stored words, and that a direct-colour load leaves later format changes without effect.

// File: rtl/palconv_pkg.sv
package palconv_pkg;
  localparam int PAL_MAX   = 256;
  localparam int IDX_W     = $clog2(PAL_MAX);
  localparam int WORD_W    = 32;
  localparam int CH_W      = 8;
  localparam int ENTRY_W   = 3 * CH_W + 1;
  localparam int FLAG_BIT  = 24;

  typedef struct packed {
    logic             capture;
    logic             emit;
    logic             useRaw;
    logic             last;
    logic [IDX_W-1:0] idx;
    logic [1:0]       fmt;
    logic             mono;
  } ctrlStrobe_t;

  function automatic logic [IDX_W:0] entryCount(input logic [3:0] code);
    case (code)
      4'd1:    entryCount = (IDX_W + 1)'(4);
      4'd2:    entryCount = (IDX_W + 1)'(16);
      4'd3:    entryCount = (IDX_W + 1)'(PAL_MAX);
      default: entryCount = '0;
    endcase
  endfunction

  function automatic logic [ENTRY_W-1:0] decodeEntry(input logic [WORD_W-1:0] w,
                                                      input logic [1:0] fmt,
                                                      input logic mono);
    logic [CH_W-1:0] r, g, b;
    logic            t;
    case (fmt)
      2'd0, 2'd1: begin
        r = {w[15:11], 3'b000};
        g = {w[10:5], 2'b00};
        b = {w[4:0], 3'b000};
      end
      2'd2: begin
        r = {w[23:19], 3'b000};
        g = {w[15:10], 2'b00};
        b = {w[7:3], 3'b000};
      end
      default: begin
        r = w[23:16];
        g = w[15:8];
        b = w[7:0];
      end
    endcase
    t = (fmt == 2'd0) ? 1'b0 : w[FLAG_BIT];
    if (mono) begin
      r = w[7:0];
      g = w[7:0];
      b = w[7:0];
    end
    decodeEntry = {t, r, g, b};
  endfunction
endpackage

// File: rtl/palconv_ctrl.sv
module palconv_ctrl
  import palconv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadStart,
  input  logic [3:0]  depthCode,
  input  logic [1:0]  palFormat,
  input  logic        monoSel,
  input  logic        wordValid,
  output ctrlStrobe_t stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_REPLAY} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic [1:0]       fmtUsed;
  logic             monoUsed;
  logic             loaded;
  logic [IDX_W:0]   startCount;

  assign startCount = entryCount(depthCode);

  always_comb begin
    stb      = '0;
    stb.idx  = idx;
    stb.fmt  = fmtUsed;
    stb.mono = monoUsed;
    stb.last = (idx == lastIdx);
    if (!loadStart) begin
      case (state)
        ST_LOAD: begin
          stb.capture = wordValid;
          stb.emit    = wordValid;
        end
        ST_REPLAY: begin
          stb.emit   = 1'b1;
          stb.useRaw = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      lastIdx  <= '0;
      fmtUsed  <= '0;
      monoUsed <= 1'b0;
      loaded   <= 1'b0;
    end else if (loadStart) begin
      idx      <= '0;
      loaded   <= 1'b0;
      fmtUsed  <= palFormat;
      monoUsed <= monoSel;
      lastIdx  <= IDX_W'(startCount - 1'b1);
      state    <= (startCount == '0) ? ST_IDLE : ST_LOAD;
    end else begin
      case (state)
        ST_IDLE: begin
          if (loaded && (palFormat != fmtUsed)) begin
            state    <= ST_REPLAY;
            idx      <= '0;
            fmtUsed  <= palFormat;
            monoUsed <= monoSel;
          end
        end
        ST_LOAD, ST_REPLAY: begin
          if (stb.emit) begin
            if (stb.last) begin
              state  <= ST_IDLE;
              loaded <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: nothing is produced while no load or reconversion is running
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !stb.emit);

  // R10: a reconversion streams stored words every cycle
  p_replay_streams_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REPLAY && !loadStart) |-> (stb.emit && stb.useRaw));

  // R2: the entry index advances by exactly one between entries
  p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.emit && !stb.last && !loadStart) |=> idx == IDX_W'($past(idx) + 1'b1));

  // R3: a direct-colour depth code leaves the block idle with nothing stored
  p_direct_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStart && startCount == '0) |=> (state == ST_IDLE && !loaded));
endmodule

// File: rtl/palconv_datapath.sv
module palconv_datapath
  import palconv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        stb,
  input  logic [WORD_W-1:0]  wordData,
  output logic               wrEn,
  output logic [IDX_W-1:0]   wrAddr,
  output logic [ENTRY_W-1:0] wrData,
  output logic               convDone
);
  logic [WORD_W-1:0] rawStore [PAL_MAX];
  logic [WORD_W-1:0] srcWord;

  always_ff @(posedge clk) begin
    if (stb.capture) rawStore[stb.idx] <= wordData;
  end

  assign srcWord = stb.useRaw ? rawStore[stb.idx] : wordData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      convDone <= 1'b0;
    end else begin
      wrEn     <= stb.emit;
      convDone <= stb.emit && stb.last;
      if (stb.emit) begin
        wrAddr <= stb.idx;
        wrData <= decodeEntry(srcWord, stb.fmt, stb.mono);
      end
    end
  end

  // R2: completion only ever accompanies a write
  p_done_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |-> wrEn);

  // R2: each emit becomes a write at the captured index one cycle later
  p_addr_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.emit |=> (wrEn && wrAddr == $past(stb.idx)));

  // R4: format 0 never sets the transparency flag
  p_fmt0_opaque_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.emit && stb.fmt == 2'd0) |=> !wrData[ENTRY_W-1]);

  // R4: 5-6-5 widening leaves zeros in the low bits
  p_widen_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.emit && !stb.mono && !stb.fmt[1]) |=>
      (wrData[18:16] == 3'b000 && wrData[9:8] == 2'b00 && wrData[2:0] == 3'b000));

  // R8: greyscale output has three equal channels
  p_mono_grey_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.emit && stb.mono) |=> (wrData[23:16] == wrData[15:8] && wrData[15:8] == wrData[7:0]));
endmodule

// File: rtl/palconv_top.sv
module palconv_top
  import palconv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadStart,
  input  logic [3:0]  depthCode,
  input  logic [1:0]  palFormat,
  input  logic        monoSel,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  output logic        wrEn,
  output logic [7:0]  wrAddr,
  output logic [24:0] wrData,
  output logic        convDone
);
  ctrlStrobe_t stb;

  palconv_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .loadStart (loadStart),
    .depthCode (depthCode),
    .palFormat (palFormat),
    .monoSel   (monoSel),
    .wordValid (wordValid),
    .stb       (stb)
  );

  palconv_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wordData (wordData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .convDone (convDone)
  );
endmodule

// File: tb/tb_palconv_top.sv
`timescale 1ns/1ps
module tb_palconv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadStart = 1'b0;
  logic [3:0]  depthCode = '0;
  logic [1:0]  palFormat = '0;
  logic        monoSel = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wrEn;
  logic [7:0]  wrAddr;
  logic [24:0] wrData;
  logic        convDone;

  int total = 0;
  int bad = 0;
  int spurious = 0;
  string curReq = "R1";
  logic [33:0] expQ[$];
  logic [31:0] saved [256];

  always #4 clk = ~clk;

  palconv_top dut (
    .clk(clk), .rst_n(rst_n), .loadStart(loadStart), .depthCode(depthCode),
    .palFormat(palFormat), .monoSel(monoSel), .wordValid(wordValid),
    .wordData(wordData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .convDone(convDone)
  );

  function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f, input bit m);
    logic [7:0] r, g, b;
    logic t;
    if (f == 2'd3) begin
      r = w[23:16]; g = w[15:8]; b = w[7:0];
    end else if (f == 2'd2) begin
      r = w[23:16] & 8'hF8; g = w[15:8] & 8'hFC; b = w[7:0] & 8'hF8;
    end else begin
      r = {w[15:11], 3'd0}; g = {w[10:5], 2'd0}; b = {w[4:0], 3'd0};
    end
    t = (f != 2'd0) && w[24];
    if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {t, r, g, b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && wrEn) begin
      if (expQ.size() == 0) begin
        spurious++;
        check(1'b0, curReq, "unexpected write", {38'd0, convDone, wrAddr, wrData}, 64'd0);
      end else begin
        logic [33:0] e;
        e = expQ.pop_front();
        check({convDone, wrAddr, wrData} == e, curReq, "entry",
              {30'd0, convDone, wrAddr, wrData}, {30'd0, e});
      end
    end
  end

  task automatic runLoad(input logic [3:0] code, input logic [1:0] fmt, input bit mono,
                         input int n, input int extra, input logic [31:0] seed);
    @(negedge clk);
    depthCode = code; palFormat = fmt; monoSel = mono; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    for (int i = 0; i < n + extra; i++) begin
      logic [31:0] w;
      w = (seed * 32'h9E3779B1) ^ (i * 32'h01234567) ^ {i[7:0], 24'h5A3C96};
      wordData = w;
      wordValid = 1'b1;
      if (i < n) begin
        saved[i] = w;
        expQ.push_back({(i == n - 1), 8'(i), model(w, fmt, mono)});
      end
      @(negedge clk);
    end
    wordValid = 1'b0;
  endtask

  task automatic runReplay(input logic [1:0] fmt, input bit mono, input int n);
    @(negedge clk);
    palFormat = fmt; monoSel = mono;
    for (int i = 0; i < n; i++)
      expQ.push_back({(i == n - 1), 8'(i), model(saved[i], fmt, mono)});
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (expQ.size() != 0 && guard < 600) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, req, "all expected entries written", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, curReq, "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(wrEn == 1'b0 && convDone == 1'b0, "R1", "outputs in reset", {62'd0, wrEn, convDone}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wrEn == 1'b0 && convDone == 1'b0, "R1", "quiet after reset", {62'd0, wrEn, convDone}, 64'd0);

    curReq = "R4";  // code 1, format 0, 4 entries and 3 surplus words (R9)
    runLoad(4'd1, 2'd0, 1'b0, 4, 3, 32'h11);
    drain("R4");
    curReq = "R9";
    check(spurious == 0, "R9", "surplus words ignored", 64'(spurious), 64'd0);

    curReq = "R9";  // words with no load running
    @(negedge clk); wordValid = 1'b1; wordData = 32'hDEADBEEF;
    repeat (5) @(negedge clk); wordValid = 1'b0;
    drain("R9");
    check(spurious == 0, "R9", "idle words ignored", 64'(spurious), 64'd0);

    curReq = "R5";
    runLoad(4'd2, 2'd1, 1'b0, 16, 0, 32'h22);
    drain("R5");
    curReq = "R6";
    runLoad(4'd2, 2'd2, 1'b0, 16, 0, 32'h33);
    drain("R6");
    curReq = "R7";
    runLoad(4'd2, 2'd3, 1'b0, 16, 0, 32'h44);
    drain("R7");

    curReq = "R2";  // full 256-entry load
    runLoad(4'd3, 2'd3, 1'b0, 256, 2, 32'h55);
    drain("R2");

    curReq = "R8";
    runLoad(4'd1, 2'd0, 1'b1, 4, 0, 32'h66);
    drain("R8");
    runLoad(4'd1, 2'd2, 1'b1, 4, 0, 32'h77);
    drain("R8");

    curReq = "R10";  // reconversion from stored words
    runLoad(4'd2, 2'd0, 1'b0, 16, 0, 32'h88);
    drain("R10");
    runReplay(2'd2, 1'b0, 16);
    drain("R10");
    runReplay(2'd3, 1'b1, 16);
    drain("R10");

    curReq = "R3";  // direct-colour codes: nothing, not even after a format change
    runLoad(4'd4, 2'd1, 1'b0, 0, 8, 32'h99);
    drain("R3");
    runLoad(4'd0, 2'd1, 1'b0, 0, 4, 32'hAA);
    @(negedge clk); palFormat = 2'd3;
    repeat (20) @(negedge clk);
    check(spurious == 0, "R3", "no writes for direct colour", 64'(spurious), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule